// File: doc/BRIEF.md
# 64-bit Compare Timer

This block is a global timer: a 64-bit up-counter and one 64-bit compare channel. It is programmed over a plain 32-bit register bus. Software can preload the counter while it is stopped. It starts the counter with a run bit and reads the count back as two 32-bit words. A read of the low word freezes the high word in a shadow register, so the two words always belong to the same count.

The compare channel sets a pending flag when the running counter equals the compare value. When auto-step is on, the channel then adds a 32-bit step to its compare value, which gives a periodic event. The interrupt output is the pending flag gated by an enable bit. Every write to the counter, compare, step or control register is confirmed by a write-done flag. That flag rises a fixed number of timer cycles after the write, modelling a synchronizer, and stays set until software writes 1 to it.

The bus takes every access in the cycle it is presented. There is no back-pressure: reads return data in the same cycle and writes take effect at the next clock edge.

Top module: `glb_cmp_timer`

## Requirements
- R1: After reset, the counter, compare value, step, control, interrupt enable, pending flag and all write-done flags read 0, and `irq_o` is low.
- R2: While control bit 0 (run) is 1, the counter grows by exactly one per clock. A carry from the low word goes into the high word.
- R3: A write to the counter low word (address 0x0) or high word (address 0x1) loads that half only while run is 0. While run is 1 such a write has no effect on the count.
- R4: The pending flag (bit 0 at address 0x7) sets one cycle after a cycle in which run is 1, control bit 1 (compare enable) is 1, and the count equals the compare value (low word at 0x2, high word at 0x3).
- R5: When control bit 2 (auto-step) is 1, each match adds the step register (address 0x4) to the compare value. Matches therefore repeat every step cycles.
- R6: `irq_o` is the pending flag ANDed with bit 0 of the enable register (address 0x6). Pending clears only when 1 is written to bit 0 of address 0x7; writing 0 there has no effect. Clearing compare enable leaves a pending flag set.
- R7: The write-done flags at address 0x8 are bit 0 for compare low, bit 1 for compare high, bit 2 for step and bit 16 for control. The flags at address 0x9 are bit 0 for counter low and bit 1 for counter high. Each flag is first visible after the third clock edge that follows the edge sampling the write.
- R8: A write-done flag stays set until 1 is written to its bit at its status address. A 0 written there leaves it unchanged.
- R9: A read of the counter low word captures the counter high word. Reads of the high word return that captured value until the next low-word read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| irq_o | output | 1 | Compare interrupt |

## Verification
The checker watches the per-cycle rules on every cycle. It checks the one-step count while running and the held count while stopped with no load. It also checks that a match always sets pending, that pending drops only on a write of 1, that a match under auto-step moves the compare value by the step, and that write-done flags never fall without a clear write. The bench scenarios show the things a single-cycle rule cannot: the exact three-cycle delay before a write-done flag appears, the period between auto-stepped interrupts, the ignored counter write while running, and the shadowed high word returning a stale value until the low word is read again.

// File: rtl/glb_cmp_pkg.sv
`timescale 1ns/1ps
package glb_cmp_pkg;

  localparam int REG_AW = 4;

  typedef enum logic [REG_AW-1:0] {
    A_CNT_LO  = 4'h0,
    A_CNT_HI  = 4'h1,
    A_CMP_LO  = 4'h2,
    A_CMP_HI  = 4'h3,
    A_STEP    = 4'h4,
    A_CTRL    = 4'h5,
    A_IRQ_EN  = 4'h6,
    A_IRQ_ST  = 4'h7,
    A_WST     = 4'h8,
    A_CNT_WST = 4'h9
  } reg_addr_e;

  // control word fields
  localparam int CTRL_W    = 3;
  localparam int CTRL_RUN  = 0;
  localparam int CTRL_CEN  = 1;
  localparam int CTRL_AUTO = 2;

  // internal write-event indices
  localparam int NUM_EV    = 6;
  localparam int EV_CMP_LO = 0;
  localparam int EV_CMP_HI = 1;
  localparam int EV_STEP   = 2;
  localparam int EV_CTRL   = 3;
  localparam int EV_CNT_LO = 4;
  localparam int EV_CNT_HI = 5;

  // bit positions inside the two status words (software visible)
  localparam int WB_CMP_LO = 0;
  localparam int WB_CMP_HI = 1;
  localparam int WB_STEP   = 2;
  localparam int WB_CTRL   = 16;
  localparam int WB_CNT_LO = 0;
  localparam int WB_CNT_HI = 1;

endpackage

// File: rtl/gct_counter.sv
`timescale 1ns/1ps
// 2*DW-bit up-counter with per-half load while stopped (R2, R3)
module gct_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DW-1:0] ld_data,
  output logic [2*DW-1:0] cnt
);
  localparam int CW = 2 * DW;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + ONE;
    end else begin
      if (ld_lo) cnt[DW-1:0]  <= ld_data;
      if (ld_hi) cnt[CW-1:DW] <= ld_data;
    end
  end
endmodule

// File: rtl/gct_compare.sv
`timescale 1ns/1ps
// compare channel: match detect, auto-step, pending flag (R4, R5, R6)
module gct_compare #(
  parameter int DW = 32,
  parameter int IW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*DW-1:0] cnt,
  input  logic            run,
  input  logic            cmp_en,
  input  logic            auto_en,
  input  logic [IW-1:0]   step,
  input  logic            wr_lo,
  input  logic            wr_hi,
  input  logic [DW-1:0]   wr_data,
  input  logic            clr_pend,
  output logic [2*DW-1:0] cmp,
  output logic            match,
  output logic            pend
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] step_ext;

  always_comb begin
    step_ext = '0;
    step_ext[IW-1:0] = step;
  end

  assign match = run && cmp_en && (cnt == cmp);

  // bus writes take priority over the auto-step update
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (wr_lo || wr_hi) begin
      if (wr_lo) cmp[DW-1:0]  <= wr_data;
      if (wr_hi) cmp[CW-1:DW] <= wr_data;
    end else if (match && auto_en) begin
      cmp <= cmp + step_ext;
    end
  end

  // a new match wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (match)    pend <= 1'b1;
    else if (clr_pend) pend <= 1'b0;
  end
endmodule

// File: rtl/gct_wstat.sv
`timescale 1ns/1ps
// write-done flags: LAT-stage delay line feeding sticky bits (R7, R8)
module gct_wstat #(
  parameter int NEV = 6,
  parameter int LAT = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] ev,
  input  logic [NEV-1:0] clr,
  output logic [NEV-1:0] flags
);
  logic [NEV-1:0] dly [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly[0] <= '0;
        else        dly[0] <= ev;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dly[i] <= '0;
        else        dly[i] <= dly[i-1];
      end
    end
  end

  // arrival beats a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr) | dly[LAT-1];
  end
endmodule

// File: rtl/glb_cmp_timer.sv
`timescale 1ns/1ps
module glb_cmp_timer
  import glb_cmp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INC_W   = 32,
  parameter int WST_LAT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int CNT_W = 2 * DATA_W;

  logic              wr_en, rd_en;
  logic [CTRL_W-1:0] ctrl_q;
  logic              irq_en_q;
  logic [INC_W-1:0]  step_q;
  logic [DATA_W-1:0] shadow_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cmp_q;
  logic              run_en, cmp_en, auto_en;
  logic              match, pend;
  logic [NUM_EV-1:0] wr_ev, wst_clr, wst;
  logic              clr_pend;

  assign wr_en   = bus_req &&  bus_we;
  assign rd_en   = bus_req && !bus_we;
  assign run_en  = ctrl_q[CTRL_RUN];
  assign cmp_en  = ctrl_q[CTRL_CEN];
  assign auto_en = ctrl_q[CTRL_AUTO];

  // write decode into event vector and clear vector
  always_comb begin
    wr_ev = '0;
    wst_clr = '0;
    clr_pend = 1'b0;
    if (wr_en) begin
      case (bus_addr)
        A_CNT_LO:  wr_ev[EV_CNT_LO] = 1'b1;
        A_CNT_HI:  wr_ev[EV_CNT_HI] = 1'b1;
        A_CMP_LO:  wr_ev[EV_CMP_LO] = 1'b1;
        A_CMP_HI:  wr_ev[EV_CMP_HI] = 1'b1;
        A_STEP:    wr_ev[EV_STEP]   = 1'b1;
        A_CTRL:    wr_ev[EV_CTRL]   = 1'b1;
        A_IRQ_ST:  clr_pend = bus_wdata[0];
        A_WST: begin
          wst_clr[EV_CMP_LO] = bus_wdata[WB_CMP_LO];
          wst_clr[EV_CMP_HI] = bus_wdata[WB_CMP_HI];
          wst_clr[EV_STEP]   = bus_wdata[WB_STEP];
          wst_clr[EV_CTRL]   = bus_wdata[WB_CTRL];
        end
        A_CNT_WST: begin
          wst_clr[EV_CNT_LO] = bus_wdata[WB_CNT_LO];
          wst_clr[EV_CNT_HI] = bus_wdata[WB_CNT_HI];
        end
        default: ;
      endcase
    end
  end

  // control, step, enable and shadow registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      irq_en_q <= 1'b0;
      step_q   <= '0;
      shadow_q <= '0;
    end else begin
      if (wr_ev[EV_CTRL])                  ctrl_q   <= bus_wdata[CTRL_W-1:0];
      if (wr_en && bus_addr == A_IRQ_EN)   irq_en_q <= bus_wdata[0];
      if (wr_ev[EV_STEP])                  step_q   <= bus_wdata[INC_W-1:0];
      if (rd_en && bus_addr == A_CNT_LO)   shadow_q <= cnt_q[CNT_W-1:DATA_W];
    end
  end

  gct_counter #(.DW(DATA_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_en),
    .ld_lo   (wr_ev[EV_CNT_LO]),
    .ld_hi   (wr_ev[EV_CNT_HI]),
    .ld_data (bus_wdata),
    .cnt     (cnt_q)
  );

  gct_compare #(.DW(DATA_W), .IW(INC_W)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (cnt_q),
    .run      (run_en),
    .cmp_en   (cmp_en),
    .auto_en  (auto_en),
    .step     (step_q),
    .wr_lo    (wr_ev[EV_CMP_LO]),
    .wr_hi    (wr_ev[EV_CMP_HI]),
    .wr_data  (bus_wdata),
    .clr_pend (clr_pend),
    .cmp      (cmp_q),
    .match    (match),
    .pend     (pend)
  );

  gct_wstat #(.NEV(NUM_EV), .LAT(WST_LAT)) u_wst (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (wr_ev),
    .clr   (wst_clr),
    .flags (wst)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO:  bus_rdata = cnt_q[DATA_W-1:0];
      A_CNT_HI:  bus_rdata = shadow_q;
      A_CMP_LO:  bus_rdata = cmp_q[DATA_W-1:0];
      A_CMP_HI:  bus_rdata = cmp_q[CNT_W-1:DATA_W];
      A_STEP:    bus_rdata[INC_W-1:0]  = step_q;
      A_CTRL:    bus_rdata[CTRL_W-1:0] = ctrl_q;
      A_IRQ_EN:  bus_rdata[0] = irq_en_q;
      A_IRQ_ST:  bus_rdata[0] = pend;
      A_WST: begin
        bus_rdata[WB_CMP_LO] = wst[EV_CMP_LO];
        bus_rdata[WB_CMP_HI] = wst[EV_CMP_HI];
        bus_rdata[WB_STEP]   = wst[EV_STEP];
        bus_rdata[WB_CTRL]   = wst[EV_CTRL];
      end
      A_CNT_WST: begin
        bus_rdata[WB_CNT_LO] = wst[EV_CNT_LO];
        bus_rdata[WB_CNT_HI] = wst[EV_CNT_HI];
      end
      default: ;
    endcase
  end

  assign irq_o = pend && irq_en_q;

endmodule

// File: rtl/glb_cmp_timer_chk.sv
`timescale 1ns/1ps
module glb_cmp_timer_chk
  import glb_cmp_pkg::*;
#(
  parameter int DW  = 32,
  parameter int IW  = 32,
  parameter int NEV = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_we,
  input logic [REG_AW-1:0] bus_addr,
  input logic              wd0,
  input logic              irq_o,
  input logic [2*DW-1:0]   cnt,
  input logic [2*DW-1:0]   cmp,
  input logic [IW-1:0]     step,
  input logic              run,
  input logic              auto_en,
  input logic              match,
  input logic              pend,
  input logic [NEV-1:0]    wst
);
  localparam int CW = 2 * DW;
  localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

  logic wr, cnt_wr, cmp_wr, pend_clr_wr, wst_wr;
  logic [CW-1:0] step_ext;

  assign wr          = bus_req && bus_we;
  assign cnt_wr      = wr && (bus_addr == A_CNT_LO || bus_addr == A_CNT_HI);
  assign cmp_wr      = wr && (bus_addr == A_CMP_LO || bus_addr == A_CMP_HI);
  assign pend_clr_wr = wr && bus_addr == A_IRQ_ST && wd0;
  assign wst_wr      = wr && (bus_addr == A_WST || bus_addr == A_CNT_WST);

  always_comb begin
    step_ext = '0;
    step_ext[IW-1:0] = step;
  end

  // R2
  run_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + ONE);

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  // R4
  match_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> pend);

  // R5
  auto_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match && auto_en && !cmp_wr) |=> cmp == $past(cmp) + $past(step_ext));

  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !pend_clr_wr) |=> pend);

  // R6
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> pend);

  // R8
  wst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wst_wr |=> ((wst & $past(wst)) == $past(wst)));

endmodule

bind glb_cmp_timer glb_cmp_timer_chk #(
  .DW(DATA_W), .IW(INC_W), .NEV(glb_cmp_pkg::NUM_EV)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_req  (bus_req),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .wd0      (bus_wdata[0]),
  .irq_o    (irq_o),
  .cnt      (cnt_q),
  .cmp      (cmp_q),
  .step     (step_q),
  .run      (run_en),
  .auto_en  (auto_en),
  .match    (match),
  .pend     (pend),
  .wst      (wst)
);

// File: tb/glb_cmp_timer_test.sv
`timescale 1ns/1ps
module glb_cmp_timer_test;
  import glb_cmp_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  glb_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  // monitor: compares read data mid-cycle, before the sampling edge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (bus_req && !bus_we) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL scoreboard empty: got %h expected none", bus_rdata);
        end else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq_o !== e) begin
      bad++;
      $display("FAIL %s: got %b expected %b", t, irq_o, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(A_CNT_LO, 32'h0, "R1 cnt lo");
    rd(A_CNT_HI, 32'h0, "R1 cnt hi");
    rd(A_CMP_LO, 32'h0, "R1 cmp lo");
    rd(A_CTRL,   32'h0, "R1 ctrl");
    rd(A_IRQ_ST, 32'h0, "R1 pending");
    rd(A_WST,    32'h0, "R1 wstat");

    // R7 latency: three edges after the write edge
    wr(A_CMP_LO, 32'h55);
    rd(A_WST, 32'h0, "R7 wst +1");
    rd(A_WST, 32'h0, "R7 wst +2");
    rd(A_WST, 32'h0, "R7 wst +3");
    rd(A_WST, 32'h1, "R7 wst +4");
    // R7 bit positions
    wr(A_CMP_HI, 32'h0);
    wr(A_STEP,   32'h5);
    wr(A_CTRL,   32'h0);
    wr(A_CNT_LO, 32'h0);
    wr(A_CNT_HI, 32'h0);
    idle(4);
    rd(A_WST,     32'h0001_0007, "R7 wst map");
    rd(A_CNT_WST, 32'h0000_0003, "R7 cnt wst map");
    // R8 sticky / write-1 clear
    wr(A_WST, 32'h1);
    rd(A_WST, 32'h0001_0006, "R8 clear bit0");
    wr(A_WST, 32'h0);
    rd(A_WST, 32'h0001_0006, "R8 zero write");
    wr(A_CNT_WST, 32'h2);
    rd(A_CNT_WST, 32'h1, "R8 cnt clear bit1");
    wr(A_WST, 32'hFFFF_FFFF);
    wr(A_CNT_WST, 32'h3);
    rd(A_WST, 32'h0, "R8 all cleared");
    rd(A_CNT_WST, 32'h0, "R8 cnt all cleared");

    // R2 run with carry, R9 coherent read
    wr(A_CNT_LO, 32'hFFFF_FFF8);
    wr(A_CNT_HI, 32'h5);
    wr(A_CTRL, 32'h1);
    idle(10);
    wr(A_CTRL, 32'h0);
    rd(A_CNT_LO, 32'h3, "R2 lo after 11 steps");
    rd(A_CNT_HI, 32'h6, "R2 hi carry");
    wr(A_CNT_HI, 32'h9);
    rd(A_CNT_HI, 32'h6, "R9 shadow stale");
    rd(A_CNT_LO, 32'h3, "R9 lo");
    rd(A_CNT_HI, 32'h9, "R9 shadow refreshed");

    // R3 counter write ignored while running
    wr(A_CTRL, 32'h1);
    wr(A_CNT_LO, 32'h1234);
    wr(A_CTRL, 32'h0);
    rd(A_CNT_LO, 32'h5, "R3 write ignored");
    rd(A_CNT_HI, 32'h9, "R3 hi");

    // R4 / R5 periodic compare
    wr(A_CNT_LO, 32'h0);
    wr(A_CNT_HI, 32'h0);
    wr(A_CMP_LO, 32'd20);
    wr(A_CMP_HI, 32'h0);
    wr(A_STEP, 32'd10);
    wr(A_IRQ_EN, 32'h1);
    wr(A_CTRL, 32'h7);
    idle(20);
    chk_irq(1'b0, "R4 before match");
    idle(1);
    chk_irq(1'b1, "R4 at match");
    wr(A_IRQ_ST, 32'h1);
    chk_irq(1'b0, "R6 cleared");
    idle(8);
    chk_irq(1'b0, "R5 before period");
    idle(1);
    chk_irq(1'b1, "R5 periodic match");
    rd(A_CMP_LO, 32'd40, "R5 compare stepped twice");
    // R6 disabling compare keeps pending
    wr(A_CTRL, 32'h1);
    chk_irq(1'b1, "R6 pend survives cmp disable");
    wr(A_IRQ_EN, 32'h0);
    chk_irq(1'b0, "R6 gated by enable");
    rd(A_IRQ_ST, 32'h1, "R6 pending visible");
    wr(A_IRQ_ST, 32'h0);
    rd(A_IRQ_ST, 32'h1, "R6 zero write no clear");
    wr(A_IRQ_ST, 32'h1);
    rd(A_IRQ_ST, 32'h0, "R6 one write clears");
    idle(20);
    rd(A_IRQ_ST, 32'h0, "R4 no match when disabled");
    wr(A_CTRL, 32'h0);

    idle(2);
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule